// File: doc/BRIEF.md
# Serial (7,4) Cyclic Encoder and Syndrome Corrector

This block handles one 7-bit word of a systematic cyclic code built on the generator g(x) = x^3 + x^2 + 1. Both directions share a single three-stage division register. A `start` pulse clears that register and latches the direction from `mode`.

In encode mode (`mode` = 0) the four message bits pass through to the serial output as they arrive, and at the same time they are divided into the register. Once the fourth bit is in, the feedback is switched off. The register then shifts its remainder out as three check bits on the next three cycles.

In decode mode (`mode` = 1) seven received bits are divided into the cleared register and copied into a word buffer. One cycle after the last bit, the block reports three results together for a single cycle: the remainder as the syndrome, the buffered word with the matching single-bit error pattern XORed in, and an error flag.

Top module: `cyc74_codec`

## Requirements
- R1: After reset, `code_valid`, `dec_valid` and `err_flag` are low, and `syndrome` and `dec_word` are zero.
- R2: In encode mode, each accepted message bit appears on `code_bit` with `code_valid` high on the cycle after it is taken. The bits keep their arrival order, with M3 first.
- R3: The three check bits follow the fourth message bit on consecutive cycles, C2 first. They are the remainder of x^3·m(x) divided by x^3+x^2+1, so the 7-bit stream M3 M2 M1 M0 C2 C1 C0 is a multiple of g(x).
- R4: A cycle with `in_valid` low shifts nothing and produces nothing. A bit offered in the same cycle as `start` is ignored.
- R5: In decode mode the first received bit is the coefficient of x^6 and lands in `dec_word[6]`. `syndrome` is the remainder of the received word divided by g(x), with `syndrome[2]` the x^2 coefficient. It is reported on the cycle after the one that took the seventh bit.
- R6: `dec_valid` is high for exactly one cycle per completed received word.
- R7: A nonzero syndrome s flips exactly the single bit p of the word for which x^p mod g(x) equals s. For example, received 1101101 gives syndrome 101, and the block returns 1100101 with `err_flag` high.
- R8: A zero syndrome returns the buffered word unchanged with `err_flag` low.
- R9: Any cyclic rotation of a valid codeword decodes with a zero syndrome.
- R10: A `start` during a word abandons that word. The bits already passed through in encode mode stay emitted, and no check bits or decode result follow. A `start` in the cycle where a decode result is being issued still lets that result out, and the new word begins normally.
- R11: The direction is taken from `mode` only in the `start` cycle. Changing `mode` during a word has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a new word; clears the division register |
| mode | input | 1 | 0 = encode, 1 = decode; sampled with `start` |
| in_valid | input | 1 | `in_bit` carries a message or received bit |
| in_bit | input | 1 | Serial input bit |
| code_bit | output | 1 | Serial codeword bit |
| code_valid | output | 1 | `code_bit` is valid this cycle |
| syndrome | output | 3 | Remainder of the last decoded word |
| dec_word | output | 7 | Corrected word, first received bit in bit 6 |
| dec_valid | output | 1 | One-cycle strobe for `syndrome`, `dec_word` and `err_flag` |
| err_flag | output | 1 | Nonzero syndrome on the last decoded word |

## Verification
A decode result is issued in the cycle after the seventh bit. A new `start` can arrive in that same cycle, so a result release and a register clear can land on one clock edge. The bench drives `start` for an encode word in exactly that cycle. It then judges the two outcomes separately: the decoded word, syndrome and flag must match the word that just ended, and the following 7-bit serial codeword must match the new message. A second case aborts an encode word after two bits with a decode `start`. Exactly two pass-through bits must have been emitted, no check bits may follow, and the decode must be correct.

// File: rtl/cyc74_pkg.sv
// Package: shared phase encoding and polynomial arithmetic for the cyclic codec.
// Assumes generator polynomials of degree at most 16.
package cyc74_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_CHK  = 2'd2,
        PH_FIX  = 2'd3
    } phase_t;

    // Returns x^p mod g(x), where g has degree q and is given with its x^q term.
    function automatic logic [15:0] pow_mod(input int p, input int q, input logic [16:0] g);
        logic [16:0] acc;
        acc = 17'd1;
        for (int i = 0; i < p; i++) begin
            acc = acc << 1;
            if (acc[q]) acc = acc ^ g;
        end
        return acc[15:0];
    endfunction

endpackage

// File: rtl/cyc_divider.sv
// Module: bit-serial division register for a degree-Q generator.
// In premultiplied form the input joins the feedback, so the register divides x^Q*m(x).
// In plain form the input enters the low stage, so it divides r(x).
// With open_fb high, the feedback and input are cut and the register shifts toward the top stage.
// Assumes Q >= 2 and that the g0 coefficient is 1.
module cyc_divider #(
    parameter int Q = 3,
    parameter logic [Q-1:0] GLOW = 3'b101
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic         premul,
    input  logic         open_fb,
    input  logic         din,
    output logic [Q-1:0] rem
);
    logic [Q-1:0] r_q;
    logic [Q-1:0] nxt;
    logic         fb;
    logic         low_in;

    // Next register value from the feedback bit and the polynomial taps.
    always_comb begin
        fb     = open_fb ? 1'b0 : (r_q[Q-1] ^ (premul & din));
        low_in = ~premul & ~open_fb & din;
        nxt[0] = low_in ^ (GLOW[0] & fb);
        for (int i = 1; i < Q; i++) begin
            nxt[i] = r_q[i-1] ^ (GLOW[i] & fb);
        end
    end

    // Register update: clear has priority over a shift.
    always_ff @(posedge clk) begin
        if (!rst_n)    r_q <= '0;
        else if (clr)  r_q <= '0;
        else if (step) r_q <= nxt;
    end

    assign rem = r_q;

    p_clear_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rem == '0));

    p_open_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && open_fb && !clr) |=> (rem[0] == 1'b0 && rem[Q-1] == $past(rem[Q-2])));

endmodule

// File: rtl/cyc_err_map.sv
// Module: maps a syndrome to the single-bit error pattern whose remainder matches it.
// The table is computed at elaboration as x^p mod g(x) for each bit position p.
// Assumes the generator separates all N unit vectors (true for a Hamming-length code).
module cyc_err_map #(
    parameter int N = 7,
    parameter int Q = 3,
    parameter logic [16:0] GFULL = 17'b1101
) (
    input  logic [Q-1:0] syn,
    output logic [N-1:0] pat
);
    import cyc74_pkg::*;

    // One comparator per bit position against its precomputed remainder.
    for (genvar p = 0; p < N; p++) begin : g_pos
        localparam logic [15:0] SF = pow_mod(p, Q, GFULL);
        assign pat[p] = (syn == SF[Q-1:0]);
    end

    // Checks that at most one error position is ever selected.
    always_comb begin
        a_single_position_r7: assert ($onehot0(pat));
    end

endmodule

// File: rtl/cyc74_codec.sv
// Module: serial systematic (N,K) cyclic encoder and single-error syndrome corrector.
// start clears the word and latches mode; in_valid qualifies in_bit while a word loads.
// Encode emits K pass-through bits, then Q check bits. Decode buffers N bits, then
// issues the syndrome, the corrected word and the error flag for one cycle.
// Assumes a g(x) that gives distinct nonzero remainders for all N positions.
module cyc74_codec #(
    parameter int N = 7,
    parameter int K = 4,
    parameter logic [N-K:0] GPOLY = 4'b1101
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mode,
    input  logic             in_valid,
    input  logic             in_bit,
    output logic             code_bit,
    output logic             code_valid,
    output logic [N-K-1:0]   syndrome,
    output logic [N-1:0]     dec_word,
    output logic             dec_valid,
    output logic             err_flag
);
    import cyc74_pkg::*;

    localparam int Q  = N - K;
    localparam int CW = $clog2(N + 1);
    localparam logic [Q-1:0] GLOW = GPOLY[Q-1:0];
    localparam logic [CW-1:0] LAST_MSG = CW'(K - 1);
    localparam logic [CW-1:0] LAST_RX  = CW'(N - 1);
    localparam logic [CW-1:0] LAST_CHK = CW'(Q - 1);

    phase_t        phase;
    logic          dec_mode;
    logic [CW-1:0] cnt;
    logic [N-1:0]  rxbuf;
    logic [Q-1:0]  rem;
    logic [N-1:0]  pat;
    logic          accept;
    logic          div_step;

    assign accept   = in_valid && (phase == PH_LOAD) && !start;
    assign div_step = accept || (phase == PH_CHK);

    cyc_divider #(.Q(Q), .GLOW(GLOW)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start),
        .step    (div_step),
        .premul  (!dec_mode),
        .open_fb (phase == PH_CHK),
        .din     (in_bit),
        .rem     (rem)
    );

    cyc_err_map #(.N(N), .Q(Q), .GFULL(17'(GPOLY))) u_map (
        .syn (rem),
        .pat (pat)
    );

    // Phase sequencing: load bits, then shift checks (encode) or issue the result (decode).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            dec_mode <= 1'b0;
            cnt      <= '0;
        end else if (start) begin
            phase    <= PH_LOAD;
            dec_mode <= mode;
            cnt      <= '0;
        end else begin
            case (phase)
                PH_LOAD: if (accept) begin
                    if (cnt == (dec_mode ? LAST_RX : LAST_MSG)) begin
                        phase <= dec_mode ? PH_FIX : PH_CHK;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_CHK: begin
                    if (cnt == LAST_CHK) phase <= PH_IDLE;
                    cnt <= cnt + 1'b1;
                end
                PH_FIX:  phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Received-word buffer, first bit ending up at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)                 rxbuf <= '0;
        else if (accept && dec_mode) rxbuf <= {rxbuf[N-2:0], in_bit};
    end

    // Serial encoder output: pass-through bits, then the register's top stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_bit   <= 1'b0;
            code_valid <= 1'b0;
        end else begin
            code_valid <= (accept && !dec_mode) || (phase == PH_CHK && !start);
            code_bit   <= (phase == PH_CHK) ? rem[Q-1] : in_bit;
        end
    end

    // Decode result registers, loaded once in the issue phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            syndrome  <= '0;
            dec_word  <= '0;
            err_flag  <= 1'b0;
            dec_valid <= 1'b0;
        end else begin
            dec_valid <= (phase == PH_FIX);
            if (phase == PH_FIX) begin
                syndrome <= rem;
                dec_word <= rxbuf ^ pat;
                err_flag <= |rem;
            end
        end
    end

    p_result_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    p_result_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_valid) |-> $past(phase == PH_FIX));

    p_check_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CHK && !start) |=> code_valid);

    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !start) |=> (!code_valid && !dec_valid));

    p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && phase != PH_IDLE) |=> $stable(dec_mode));

endmodule

// File: tb/cyc74_codec_test.sv
// Bench: exhaustive encode and single-error decode sweeps, rotations, abort and overlap cases.
module cyc74_codec_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       mode = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_bit = 1'b0;
    logic       code_bit;
    logic       code_valid;
    logic [2:0] syndrome;
    logic [6:0] dec_word;
    logic       dec_valid;
    logic       err_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic       enc_cap [0:4095];
    int         enc_n = 0;
    logic [2:0] cap_syn [0:1023];
    logic [6:0] cap_word[0:1023];
    logic       cap_err [0:1023];
    int         dec_n = 0;

    always #10 clk = ~clk;

    cyc74_codec uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .in_valid(in_valid), .in_bit(in_bit),
        .code_bit(code_bit), .code_valid(code_valid),
        .syndrome(syndrome), .dec_word(dec_word),
        .dec_valid(dec_valid), .err_flag(err_flag)
    );

    // Capture outputs mid-cycle, away from the active edge.
    always @(negedge clk) begin
        if (code_valid && enc_n < 4096) begin
            enc_cap[enc_n] = code_bit;
            enc_n++;
        end
        if (dec_valid && dec_n < 1024) begin
            cap_syn[dec_n]  = syndrome;
            cap_word[dec_n] = dec_word;
            cap_err[dec_n]  = err_flag;
            dec_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [2:0] gmod(input logic [6:0] w);
        logic [6:0] t;
        t = w;
        for (int i = 6; i >= 3; i--) begin
            if (t[i]) t = t ^ (7'b0001101 << (i - 3));
        end
        return t[2:0];
    endfunction

    function automatic logic [6:0] encode(input logic [3:0] m);
        return {m, gmod({m, 3'b000})};
    endfunction

    task automatic pulse_start(input logic md);
        @(negedge clk);
        start = 1'b1; mode = md; in_valid = 1'b1; in_bit = 1'b1;
        @(negedge clk);
        start = 1'b0; mode = ~md;
    endtask

    // Drives len bits MSB first; with gap set, inserts an idle cycle carrying a junk 1.
    task automatic drive_bits(input logic [6:0] w, input int len, input bit gap);
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1;
            in_bit = w[len - 1 - i];
            @(negedge clk);
            if (gap && i == 1) begin
                in_valid = 1'b0; in_bit = 1'b1;
                @(negedge clk);
            end
        end
        in_valid = 1'b0; in_bit = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [6:0] enc_word(input int base);
        logic [6:0] v;
        for (int j = 0; j < 7; j++) v[6 - j] = enc_cap[base + j];
        return v;
    endfunction

    task automatic run_encode(input logic [3:0] m, input bit gap);
        int base;
        base = enc_n;
        pulse_start(1'b0);
        drive_bits({3'b000, m}, 4, gap);
        idle(5);
        chk(enc_n - base == 7, "R3 stream length", enc_n - base, 7);
        if (enc_n - base == 7) begin
            chk(enc_word(base) == encode(m), gap ? "R4 gap codeword" : "R2 R3 codeword",
                enc_word(base), encode(m));
            chk(gmod(enc_word(base)) == 3'b000, "R3 multiple of g", gmod(enc_word(base)), 0);
        end
    endtask

    task automatic run_decode(input logic [6:0] w, input logic [6:0] exp_w, input string req);
        int base;
        base = dec_n;
        pulse_start(1'b1);
        drive_bits(w, 7, 1'b0);
        idle(3);
        chk(dec_n - base == 1, "R6 one strobe", dec_n - base, 1);
        if (dec_n - base == 1) begin
            chk(cap_syn[base] == gmod(w), {req, " syndrome R5"}, cap_syn[base], gmod(w));
            chk(cap_word[base] == exp_w, {req, " word"}, cap_word[base], exp_w);
            chk(cap_err[base] == (gmod(w) != 3'b000), {req, " flag"}, cap_err[base],
                int'(gmod(w) != 3'b000));
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [6:0] cw;
        logic [6:0] rot;
        int b0;
        int d0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!code_valid && !dec_valid && !err_flag, "R1 strobes low",
            {code_valid, dec_valid, err_flag}, 0);
        chk(syndrome == 0 && dec_word == 0, "R1 results zero", {syndrome, dec_word}, 0);

        // R2 R3: all messages; R4 with an idle gap on half of them
        for (int m = 0; m < 16; m++) run_encode(4'(m), m[0]);

        // R7: worked example
        run_decode(7'b1101101, 7'b1100101, "R7 example");

        // R5 R7 R8: every codeword, clean and with each single error
        for (int m = 0; m < 16; m++) begin
            cw = encode(4'(m));
            run_decode(cw, cw, "R8 clean");
            for (int e = 0; e < 7; e++) run_decode(cw ^ (7'd1 << e), cw, "R7 single");
        end

        // R9: rotations of codewords
        for (int m = 1; m < 16; m++) begin
            cw = encode(4'(m));
            for (int s = 1; s < 7; s++) begin
                rot = (cw << s) | (cw >> (7 - s));
                run_decode(rot, rot, "R9 rotation");
            end
        end

        // R10: start in the result cycle begins an encode word
        b0 = enc_n; d0 = dec_n;
        cw = encode(4'b1011) ^ 7'b0000100;
        pulse_start(1'b1);
        drive_bits(cw, 7, 1'b0);
        start = 1'b1; mode = 1'b0;
        @(negedge clk);
        start = 1'b0; mode = 1'b1;
        drive_bits(7'b0000110, 4, 1'b0);
        idle(5);
        chk(dec_n - d0 == 1 && cap_word[d0] == encode(4'b1011), "R10 overlap result",
            cap_word[d0], encode(4'b1011));
        chk(enc_n - b0 == 7 && enc_word(b0) == encode(4'b0110), "R10 overlap next word",
            enc_word(b0), encode(4'b0110));

        // R10: abort an encode word after two bits with a decode start
        b0 = enc_n; d0 = dec_n;
        pulse_start(1'b0);
        drive_bits(7'b0000011, 2, 1'b0);
        cw = encode(4'b1001) ^ 7'b1000000;
        run_decode(cw, encode(4'b1001), "R10 after abort");
        chk(enc_n - b0 == 2, "R10 abort emits only pass bits", enc_n - b0, 2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule